// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block sits between a processor and a slower word-wide memory. It caches 12-bit words of a 15-bit word address space in 512 sets. Each set has two entries, and each entry holds a 6-bit tag, a data word and a valid bit. The address splits into a tag in the high bits and a set index in the low bits. A read whose tag matches a valid entry in its set is answered from the cache without touching memory. A read that matches neither entry fetches the word over a request/acknowledge memory port, stores it in the set and returns it.

Each entry also keeps a one-bit use flag. The flags track which of the two entries was touched least recently, and a miss replaces that entry. Writes always go to memory (write-through). A write that hits also refreshes the cached copy. A write that misses leaves the cache alone.

The processor raises `req` with `we`, `addr` and `wdata` and holds them until `ready` pulses. On a read, `rdata` is valid during that pulse.

Top module: `cache2w_ctrl`

## Requirements
- R1: The tag is `addr[14:9]` and the set index is `addr[8:0]`. Every one of the 64 tags and 512 sets is usable, including index 511 and tag 63.
- R2: A read is a hit when a valid entry of the indexed set holds the request's tag. A read hit raises `ready` with the stored word on `rdata` in the cycle after the request is first seen, and raises no `mem_req`.
- R3: On a read miss, `mem_req` rises with `mem_we`=0 and `mem_addr`=`addr` in the cycle after the request. `ready` follows in the cycle after `mem_ack`, with `rdata` equal to the `mem_rdata` sampled at that acknowledge. The word is stored, so a repeated read hits.
- R4: After reset, `ready` and `mem_req` are 0, every entry is invalid so the first read of any address misses, and both use flags of every set are 1.
- R5: A hit on one entry clears that entry's use flag and sets the other entry's flag. A write hit counts as a hit.
- R6: A read miss refills the entry whose use flag is 1, choosing entry 0 when both flags are 1. The refilled entry's flag becomes 0 and the other entry's flag becomes 1. As a result, with three tags competing for one set, the least recently touched tag is the one evicted.
- R7: The two use flags of a set are never both 0.
- R8: Every write raises `mem_req` with `mem_we`=1, `mem_addr`=`addr` and `mem_wdata`=`wdata` in the cycle after the request, and `ready` follows in the cycle after `mem_ack`. A write hit also updates the cached word, so a later read hits and returns the new word. A write miss allocates nothing, so a later read of that address misses.
- R9: `ready` is high for exactly one cycle per request. While `mem_req` waits for `mem_ack`, it stays high and `mem_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Processor request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Word address: tag in bits 14:9, index in bits 8:0 |
| wdata | input | 12 | Write data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 12 | Read data, valid with ready on reads |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 12 | Memory read data, valid with mem_ack |

## Verification
Several rules are checked in every cycle: the flag pair of the addressed set is never 00, the reaction one cycle after a request (fast answer on a read hit, fetch on a read miss, memory write on any write), the returned word after a fill, the single-cycle `ready` pulse, and a pending memory request staying put. Other behaviour only shows up over a sequence of accesses, and the bench scenarios cover it: which tag the use flags evict when three tags compete for a set, whether a write hit refreshes the cached word, and whether a write miss stays out of the cache. The bench compares hit or miss, seen as the presence of a memory transaction, against a reference model of the flags.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef struct packed {
    logic accHit;  // request seen in idle and it hits: update flags, capture word
    logic wrHit;   // write hit: refresh cached word
    logic fill;    // read miss acknowledged: refill victim entry
  } cacheStrobe_t;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WMEM, S_RESP} cacheState_t;
endpackage

// File: rtl/cache2w_dp.sv
module cache2w_dp
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cacheStrobe_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic [1:0]        useCur,
  output logic [DATA_W-1:0] rdOut
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAYS  = 2;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   wayHit;
  logic [DATA_W-1:0] wayData [WAYS];
  logic              victim;

  assign idx    = addr[IDX_W-1:0];
  assign tag    = addr[ADDR_W-1:IDX_W];
  assign hit    = |wayHit;
  // Entry 0 is replaced whenever its flag is set, which also covers the tie.
  assign victim = !useCur[0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagArr  [SETS];
    logic [DATA_W-1:0] dataArr [SETS];
    logic [SETS-1:0]   validArr;
    logic [SETS-1:0]   useArr;
    logic              isVictim;

    assign isVictim   = (victim == w[0]);
    assign wayHit[w]  = validArr[idx] && (tagArr[idx] == tag);
    assign wayData[w] = dataArr[idx];
    assign useCur[w]  = useArr[idx];

    always_ff @(posedge clk) begin
      if (strb.fill && isVictim) begin
        tagArr[idx]  <= tag;
        dataArr[idx] <= memRdata;
      end else if (strb.wrHit && wayHit[w]) begin
        dataArr[idx] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        validArr <= '0;
        useArr   <= '1;
      end else if (strb.fill) begin
        if (isVictim) validArr[idx] <= 1'b1;
        useArr[idx] <= !isVictim;
      end else if (strb.accHit) begin
        useArr[idx] <= !wayHit[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdOut <= '0;
    else if (strb.fill)   rdOut <= memRdata;
    else if (strb.accHit) rdOut <= wayHit[1] ? wayData[1] : wayData[0];
  end
endmodule

// File: rtl/cache2w_fsm.sv
module cache2w_fsm
  import cache2w_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic         hit,
  input  logic         memAck,
  output cacheStrobe_t strb,
  output logic         ready,
  output logic         memReq,
  output logic         memWe,
  output logic         idle
);
  cacheState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:  if (req) stateNxt = we ? S_WMEM : (hit ? S_RESP : S_FETCH);
      S_FETCH: if (memAck) stateNxt = S_RESP;
      S_WMEM:  if (memAck) stateNxt = S_RESP;
      S_RESP:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNxt;
  end

  assign idle        = (state == S_IDLE);
  assign strb.accHit = idle && req && hit;
  assign strb.wrHit  = idle && req && hit && we;
  assign strb.fill   = (state == S_FETCH) && memAck;
  assign ready       = (state == S_RESP);
  assign memReq      = (state == S_FETCH) || (state == S_WMEM);
  assign memWe       = (state == S_WMEM);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  cacheStrobe_t strb;
  logic         hit;
  logic         idle;
  logic [1:0]   useCur;

  assign mem_addr  = addr;
  assign mem_wdata = wdata;

  cache2w_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .hit(hit), .memAck(mem_ack),
    .strb(strb), .ready(ready), .memReq(mem_req), .memWe(mem_we), .idle(idle)
  );

  cache2w_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addr(addr), .wdata(wdata),
    .memRdata(mem_rdata), .hit(hit), .useCur(useCur), .rdOut(rdata)
  );
endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              we,
  input logic              ready,
  input logic [DATA_W-1:0] rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              idle,
  input logic              hit,
  input logic [1:0]        useCur
);
  p_flags_not_both_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    useCur != 2'b00);

  p_read_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req && !we && hit |=> ready && !mem_req);

  p_read_miss_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req && !we && !hit |=> mem_req && !mem_we);

  p_fill_returns_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> ready && (rdata == $past(mem_rdata)));

  p_write_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req && we |=> mem_req && mem_we);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

bind cache2w_ctrl cache2w_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/cache2w_ctrl_bench.sv
module cache2w_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [11:0] wdata = '0;
  logic        ready, mem_req, mem_we;
  logic [11:0] rdata, mem_wdata;
  logic [14:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [11:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int ackDelay = 0;
  logic [14:0] lastWrAddr;
  logic [11:0] lastWrData;
  logic [11:0] memW [int];

  bit       mValid [512][2];
  bit [5:0] mTag   [512][2];
  bit       mUse   [512][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w_ctrl u_cache2w_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [11:0] memVal(input logic [14:0] a);
    if (memW.exists(int'(a))) return memW[int'(a)];
    return 12'(a * 7) ^ 12'h5A3;
  endfunction

  // Reference model of hit detection and use-flag replacement; returns hit.
  function automatic bit modelAccess(input logic [14:0] a, input bit isWr);
    int i = int'(a[8:0]);
    bit [5:0] t = a[14:9];
    for (int w = 0; w < 2; w++) begin
      if (mValid[i][w] && mTag[i][w] == t) begin
        mUse[i][w] = 1'b0; mUse[i][1-w] = 1'b1;
        return 1'b1;
      end
    end
    if (!isWr) begin
      int v = mUse[i][0] ? 0 : 1;
      mValid[i][v] = 1'b1; mTag[i][v] = t;
      mUse[i][v] = 1'b0; mUse[i][1-v] = 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // Memory responder: acknowledge after ackDelay idle cycles, one-cycle ack.
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (waitCnt >= ackDelay) begin
          mem_ack = 1'b1;
          waitCnt = 0;
          if (mem_we) begin
            memW[int'(mem_addr)] = mem_wdata;
            lastWrAddr = mem_addr; lastWrData = mem_wdata;
          end else mem_rdata = memVal(mem_addr);
        end else waitCnt++;
      end
    end
  end

  task automatic doAccess(input bit w, input logic [14:0] a, input logic [11:0] d, input string rq);
    bit expHit, sawMem;
    int cyc;
    logic [11:0] expData;
    expData = memVal(a);
    expHit  = modelAccess(a, w);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    cyc = 0; sawMem = 1'b0;
    do begin
      @(negedge clk); cyc++;
      if (mem_req) sawMem = 1'b1;
    end while (!ready && cyc < 60);
    req = 1'b0;
    if (!w) begin
      check(rdata == expData, {rq, " read data"}, rdata, expData);
      check(sawMem == !expHit, {rq, " hit/miss via memory traffic"}, sawMem, !expHit);
      if (expHit) check(cyc == 1, {rq, " hit latency"}, cyc, 1);
    end else begin
      check(sawMem, {rq, " R8 write reaches memory"}, sawMem, 1);
      check(lastWrAddr == a && lastWrData == d, {rq, " R8 write addr/data"}, lastWrData, d);
    end
    @(negedge clk);
    check(!ready, {rq, " R9 ready single pulse"}, ready, 0);
  endtask

  function automatic logic [14:0] mk(input int t, input int i);
    return {6'(t), 9'(i)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 512; i++) begin
      mValid[i][0] = 0; mValid[i][1] = 0; mUse[i][0] = 1; mUse[i][1] = 1;
    end
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R4 reset ready", ready, 0);
    check(mem_req == 1'b0, "R4 reset mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && mem_req == 1'b0, "R4 idle after reset", {ready, mem_req}, 0);

    // Directed: three tags competing for set 5.
    doAccess(0, mk(1, 5), 0, "R4 first read misses");
    doAccess(0, mk(1, 5), 0, "R2 repeat read hits");
    doAccess(0, mk(2, 5), 0, "R6 fill other entry");
    doAccess(0, mk(1, 5), 0, "R5 hit refreshes tag1");
    doAccess(0, mk(3, 5), 0, "R6 evict tag2");
    doAccess(0, mk(1, 5), 0, "R5 tag1 still present");
    doAccess(0, mk(2, 5), 0, "R6 tag2 was evicted");
    doAccess(0, mk(1, 5), 0, "R7 flags consistent");
    doAccess(0, mk(3, 5), 0, "R6 tag3 evicted after tag2 fill");
    // Write miss then read, write hit then read.
    ackDelay = 2;
    doAccess(1, mk(9, 7), 12'hABC, "R8 write miss");
    doAccess(0, mk(9, 7), 0, "R8 write miss not allocated");
    doAccess(1, mk(9, 7), 12'h123, "R8 write hit");
    doAccess(0, mk(9, 7), 0, "R8 write hit refreshed word");
    // Address extremes.
    ackDelay = 0;
    doAccess(0, mk(63, 511), 0, "R1 top tag top set miss");
    doAccess(0, mk(63, 511), 0, "R1 top tag top set hit");
    doAccess(0, mk(0, 0), 0, "R3 bottom address miss");

    // Constrained random mix over a few sets and tags.
    for (int n = 0; n < 300; n++) begin
      int sel = int'($urandom_range(0, 3));
      int i   = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 256 : 511;
      int t   = ($urandom_range(0, 4) == 4) ? 63 : int'($urandom_range(0, 3));
      bit w   = ($urandom_range(0, 3) == 0);
      ackDelay = int'($urandom_range(0, 3));
      doAccess(w, mk(t, i), 12'($urandom), "R1 R5 R6 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule